// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Generator

This block raises a real-time flag at regular intervals counted in bus clock cycles. A free-running binary divider advances on every bus cycle. An expiry pulse is produced when the low bits of the divider, up to the bit picked by a 2-bit rate select, are all ones. Each expiry sets a sticky flag. Software clears the flag by writing a one to it. When the flag and its enable bit are both set, an interrupt request is raised.

The divider is never reloaded by a register write. Expiries therefore stay on a fixed grid: each one falls exactly one period after the one before, however late software clears the flag. A change of rate takes effect at the next point on the divider where the low bits of the newly selected width are all ones.

The base period is `2**BASE_LOG2` cycles. With the default `BASE_LOG2 = 13`, the four rates give 8192, 16384, 32768 and 65536 cycles.

Top module: `rti_timer`

## Requirements
- R1: The expiry period is `2**(BASE_LOG2 + rate)` bus cycles, where rate is the 2-bit select (0 to 3). With the defaults this is 8192, 16384, 32768 or 65536 cycles.
- R2: An expiry sets the flag on the clock edge that ends the period. The first expiry after reset lands on the edge that is exactly one period after reset is released.
- R3: Each expiry follows the previous one by exactly one period, whenever the flag was cleared in between.
- R4: A write to address 2 with data bit 0 set clears the flag. A write there with bit 0 clear leaves the flag unchanged.
- R5: When a clear write and an expiry fall on the same edge, the flag ends up set.
- R6: `irq_o` is high exactly when the flag and the enable bit are both set.
- R7: A write to the rate select does not restart the divider. The next expiry is the first edge on which the free-running count completes a block of the newly selected period.
- R8: Reset clears the rate select, the enable bit and the flag, and restarts the divider from zero.
- R9: Register map, read combinationally on `bus_rdata`. Address 0 holds the rate select in bits [1:0]. Address 1 holds the enable in bit 0. Address 2 holds the flag in bit 0. Address 3 and all unused bits read as zero, and writes to unused bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench counts rising edges from the release of reset. A flag set by an expiry therefore shows on the edge numbered as a whole multiple of the period, and the bench samples at the next falling edge to compare the edge count with the expected multiple. Register writes are driven so that they land on a known edge. Read data and `irq_o` are combinational from the registers, so they are checked half a cycle after that edge. The collision case places the clear write on the exact expiry edge. The rate-change case checks that the expiry falls on the divider's own grid and not one period after the write.

// File: rtl/rti_pkg.sv
package rti_pkg;
    localparam int RATE_W = 2;
    localparam int NRATE  = 1 << RATE_W;

    localparam logic [1:0] ADDR_RATE = 2'd0;
    localparam logic [1:0] ADDR_EN   = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              en;
        logic              flag;
    } rti_regs_t;
endpackage

// File: rtl/rti_divider.sv
module rti_divider
    import rti_pkg::*;
#(
    parameter int BASE_LOG2 = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              expire
);
    localparam int DIV_W = BASE_LOG2 + NRATE - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [NRATE-1:0] tap_full;

    genvar k;
    generate
        for (k = 0; k < NRATE; k++) begin : g_tap
            assign tap_full[k] = &div_q[BASE_LOG2+k-1:0];
        end
    endgenerate

    always_comb begin
        div_d  = div_q + 1'b1;
        expire = tap_full[rate];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/rti_regs.sv
module rti_regs
    import rti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              expire,
    output logic [RATE_W-1:0] rate,
    output logic              en,
    output logic              flag,
    output logic [7:0]        rdata
);
    rti_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (addr)
                ADDR_RATE: regs_d.rate = wdata[RATE_W-1:0];
                ADDR_EN:   regs_d.en   = wdata[0];
                ADDR_FLAG: if (wdata[0]) regs_d.flag = 1'b0;
                default:   ;
            endcase
        end
        if (expire) regs_d.flag = 1'b1;

        rdata = '0;
        case (addr)
            ADDR_RATE: rdata[RATE_W-1:0] = regs_q.rate;
            ADDR_EN:   rdata[0]          = regs_q.en;
            ADDR_FLAG: rdata[0]          = regs_q.flag;
            default:   rdata             = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rate = regs_q.rate;
    assign en   = regs_q.en;
    assign flag = regs_q.flag;
endmodule

// File: rtl/rti_timer.sv
module rti_timer
    import rti_pkg::*;
#(
    parameter int BASE_LOG2 = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_o
);
    logic [RATE_W-1:0] rate_q;
    logic              en_q;
    logic              flag_q;
    logic              expire;

    rti_divider #(.BASE_LOG2(BASE_LOG2)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .rate   (rate_q),
        .expire (expire)
    );

    rti_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .expire (expire),
        .rate   (rate_q),
        .en     (en_q),
        .flag   (flag_q),
        .rdata  (bus_rdata)
    );

    assign irq_o = flag_q & en_q;
endmodule

// File: rtl/rti_timer_chk.sv
module rti_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       irq_o,
    input logic       flag_q,
    input logic       expire
);
    logic clr_wr;
    assign clr_wr = bus_wr && (bus_addr == 2'd2) && bus_wdata[0];

    AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q); // R2
    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(expire)); // R2
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !expire) |=> !flag_q); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && !expire) |=> $stable(flag_q)); // R4
    AST_COLLISION_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && expire) |=> flag_q); // R5
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_q); // R6
endmodule

bind rti_timer rti_timer_chk u_chk (.*);

// File: tb/rti_timer_bench.sv
`timescale 1ns/1ps
module rti_timer_bench;
    localparam int BASE = 4;
    localparam int VEC[4][2] = '{'{0, 16}, '{1, 32}, '{2, 64}, '{3, 128}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_o;
    int         cyc;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    rti_timer #(.BASE_LOG2(BASE)) u_rti_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #0.5;
        v = int'(bus_rdata);
    endtask

    task automatic wait_flag(output int at);
        bus_addr = 2'd2;
        at = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (bus_rdata[0]) begin
                at = cyc;
                break;
            end
        end
    endtask

    initial begin
        int v, at;
        do_reset();
        // R8 R9: reset state of every address and of the request
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R8 reset readback", v, 0);
        end
        chk("R8 irq after reset", int'(irq_o), 0);

        // Table walk: period, phase, clear semantics per rate
        for (int k = 0; k < 4; k++) begin
            do_reset();
            wr(2'd0, 8'(VEC[k][0]) | 8'hFC);
            rd(2'd0, v);
            chk("R9 rate readback", v, VEC[k][0]);
            wait_flag(at);
            chk("R1 R2 first expiry edge", at, VEC[k][1]);
            chk("R6 irq masked", int'(irq_o), 0);
            wr(2'd2, 8'hFE);
            rd(2'd2, v);
            chk("R4 write zero keeps flag", v, 1);
            wr(2'd2, 8'h01);
            rd(2'd2, v);
            chk("R4 write one clears flag", v, 0);
            wait_flag(at);
            chk("R3 second expiry edge", at, 2 * VEC[k][1]);
        end

        // R6 R9: enable, request, unused bits
        do_reset();
        wr(2'd1, 8'hFF);
        rd(2'd1, v);
        chk("R9 enable readback", v, 1);
        chk("R6 irq before expiry", int'(irq_o), 0);
        wait_flag(at);
        chk("R2 expiry rate0", at, 16);
        chk("R6 irq with flag and enable", int'(irq_o), 1);
        wr(2'd2, 8'h01);
        chk("R6 irq after clear", int'(irq_o), 0);

        // R5: clear write landing on the expiry edge at 32
        while (cyc != 31) @(negedge clk);
        wr(2'd2, 8'h01);
        chk("R5 edge of write", cyc, 32);
        rd(2'd2, v);
        chk("R5 set wins over clear", v, 1);

        // R7: switch to rate 3 after edge 16; grid stays on the divider
        do_reset();
        wait_flag(at);
        chk("R7 initial rate0 expiry", at, 16);
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h01);
        wait_flag(at);
        chk("R7 expiry on divider grid", at, 128);

        // R8: reset mid-run clears state and restarts the divider
        wr(2'd1, 8'h01);
        do_reset();
        rd(2'd0, v); chk("R8 rate cleared", v, 0);
        rd(2'd1, v); chk("R8 enable cleared", v, 0);
        rd(2'd2, v); chk("R8 flag cleared", v, 0);
        wait_flag(at);
        chk("R8 restart period", at, 16);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule